// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Mux

This block is the source-operand logic in the decode stage of a five-stage in-order pipeline. The pipeline runs three instructions: a load that moves a memory word into a register, a store that moves a register into memory, and halt. The block reads the two instruction bytes held in decode. From them it works out which register indices the instruction reads and which one it will later write. It then builds the two operand values that decode passes on to execute.

The only result that can be forwarded is load data, and it can be taken from two points. The first is the memory stage, where a loaded value is about to enter the memory/writeback pipeline register. The second is the writeback stage, where that register already holds the value. Register-file read data is used only when neither stage's destination matches. A source that names no register always produces zero.

The block is purely combinational. Its outputs follow its inputs within the same cycle, so the stalling logic and the register file around it can use them without any added latency.

Top module: `dec_opnd_fwd`

## Requirements
- R1: The first instruction byte selects the operation: 0x50 is a load and 0x40 is a store. In the second byte, rA is bits [7:4] and rB is bits [3:0]. Source A equals rA for a store, and for every other operation it is the none code 4'hF.
- R2: Source B equals rB for both the load and the store.
- R3: The decode destination equals rA for a load, and for every other operation it is 4'hF.
- R4: Any other first byte, including halt (0x00), reads and writes no register: source A, source B and the destination are all 4'hF.
- R5: When a source index is 4'hF, its operand is 0, even if a stage destination also equals 4'hF.
- R6: When a source is not 4'hF and equals the memory-stage destination, its operand is the memory-stage load value. This holds even when the writeback destination matches as well.
- R7: When a source is not 4'hF, does not equal the memory-stage destination, and equals the writeback destination, its operand is the writeback value.
- R8: When a source is not 4'hF and matches neither destination, operand A is register-file port A data and operand B is register-file port B data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_op_byte | input | 8 | First instruction byte in decode (operation) |
| dec_reg_byte | input | 8 | Second instruction byte: rA in [7:4], rB in [3:0] |
| mem_dst | input | 4 | Load destination of the instruction in the memory stage |
| mem_load_val | input | 64 | Value just loaded in the memory stage |
| wb_dst | input | 4 | Load destination held in the writeback stage |
| wb_val | input | 64 | Value held in the writeback stage |
| rf_rdata_a | input | 64 | Register-file read data, port A |
| rf_rdata_b | input | 64 | Register-file read data, port B |
| src_a | output | 4 | Source A register index |
| src_b | output | 4 | Source B register index |
| dst_load | output | 4 | Decode destination index |
| opnd_a | output | 64 | Operand A value |
| opnd_b | output | 64 | Operand B value |

## Verification
The memory-stage match and the writeback-stage match can both hold at once for the same source. This happens when two loads in a row target the register that decode reads. The bench sets both destinations to the store's rA and rB, with distinct data on every path, and expects the memory-stage value on each operand. A second collision is a none source meeting a destination that is also the none code. The bench expects zero in that case, not the forwarded data.

// File: rtl/dec_opnd_pkg.sv
package dec_opnd_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned DATA_W = 64;
  localparam logic [7:0] OP_LOAD  = 8'h50;
  localparam logic [7:0] OP_STORE = 8'h40;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } op_kind_e;

  // Which path feeds an operand, listed from highest to lowest priority.
  typedef enum logic [1:0] {
    PICK_ZERO = 2'd0,
    PICK_MEM  = 2'd1,
    PICK_WB   = 2'd2,
    PICK_RF   = 2'd3
  } opnd_pick_e;
endpackage

// File: rtl/ldst_spec_decode.sv
module ldst_spec_decode
  import dec_opnd_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic [7:0]    op_byte,
  input  logic [7:0]    reg_byte,
  output logic [RW-1:0] src_a,
  output logic [RW-1:0] src_b,
  output logic [RW-1:0] dst
);
  localparam logic [RW-1:0] NONE = {RW{1'b1}};

  op_kind_e      kind;
  logic [RW-1:0] ra, rb;

  assign ra = RW'(reg_byte[7:4]);
  assign rb = RW'(reg_byte[3:0]);

  always_comb begin
    unique case (op_byte)
      OP_LOAD:  kind = KIND_LOAD;
      OP_STORE: kind = KIND_STORE;
      default:  kind = KIND_OTHER;
    endcase
  end

  always_comb begin
    src_a = NONE;
    src_b = NONE;
    dst   = NONE;
    case (kind)
      KIND_STORE: begin
        src_a = ra;
        src_b = rb;
      end
      KIND_LOAD: begin
        src_b = rb;
        dst   = ra;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_fwd_sel.sv
module opnd_fwd_sel
  import dec_opnd_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_dst,
  input  logic [DW-1:0] mem_val,
  input  logic [RW-1:0] wb_dst,
  input  logic [DW-1:0] wb_val,
  input  logic [DW-1:0] rf_val,
  output logic [DW-1:0] opnd
);
  localparam logic [RW-1:0] NONE = {RW{1'b1}};

  opnd_pick_e pick;

  always_comb begin
    if (src == NONE)         pick = PICK_ZERO;
    else if (src == mem_dst) pick = PICK_MEM;
    else if (src == wb_dst)  pick = PICK_WB;
    else                     pick = PICK_RF;
  end

  always_comb begin
    unique case (pick)
      PICK_ZERO: opnd = '0;
      PICK_MEM:  opnd = mem_val;
      PICK_WB:   opnd = wb_val;
      default:   opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/dec_opnd_fwd.sv
module dec_opnd_fwd
  import dec_opnd_pkg::*;
#(
  parameter int unsigned REG_W  = dec_opnd_pkg::REG_W,
  parameter int unsigned DATA_W = dec_opnd_pkg::DATA_W
) (
  input  logic [7:0]        dec_op_byte,
  input  logic [7:0]        dec_reg_byte,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic [DATA_W-1:0] mem_load_val,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] rf_rdata_a,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic [REG_W-1:0]  src_a,
  output logic [REG_W-1:0]  src_b,
  output logic [REG_W-1:0]  dst_load,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0][REG_W-1:0]  src_v;
  logic [NPORT-1:0][DATA_W-1:0] rf_v;
  logic [NPORT-1:0][DATA_W-1:0] opnd_v;

  ldst_spec_decode #(.RW(REG_W)) u_dec (
    .op_byte (dec_op_byte),
    .reg_byte(dec_reg_byte),
    .src_a   (src_a),
    .src_b   (src_b),
    .dst     (dst_load)
  );

  assign src_v = {src_b, src_a};
  assign rf_v  = {rf_rdata_b, rf_rdata_a};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    opnd_fwd_sel #(.RW(REG_W), .DW(DATA_W)) u_sel (
      .src    (src_v[p]),
      .mem_dst(mem_dst),
      .mem_val(mem_load_val),
      .wb_dst (wb_dst),
      .wb_val (wb_val),
      .rf_val (rf_v[p]),
      .opnd   (opnd_v[p])
    );
  end

  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];
endmodule

// File: rtl/dec_opnd_fwd_chk.sv
module dec_opnd_fwd_chk #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input logic [7:0]        dec_op_byte,
  input logic [7:0]        dec_reg_byte,
  input logic [REG_W-1:0]  mem_dst,
  input logic [DATA_W-1:0] mem_load_val,
  input logic [REG_W-1:0]  wb_dst,
  input logic [DATA_W-1:0] wb_val,
  input logic [DATA_W-1:0] rf_rdata_a,
  input logic [DATA_W-1:0] rf_rdata_b,
  input logic [REG_W-1:0]  src_a,
  input logic [REG_W-1:0]  src_b,
  input logic [REG_W-1:0]  dst_load,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);
  localparam logic [REG_W-1:0] NONE = {REG_W{1'b1}};

  logic known;
  assign known = !$isunknown({dec_op_byte, dec_reg_byte, mem_dst, wb_dst,
                              mem_load_val, wb_val, rf_rdata_a, rf_rdata_b});

  always_comb begin
    if (known) begin
      p_src_a_spec_r1: assert (dec_op_byte != 8'h40 || src_a == REG_W'(dec_reg_byte[7:4]));
      p_src_b_spec_r2: assert (!(dec_op_byte == 8'h40 || dec_op_byte == 8'h50)
                               || src_b == REG_W'(dec_reg_byte[3:0]));
      p_dst_spec_r3:   assert (dec_op_byte != 8'h50 || dst_load == REG_W'(dec_reg_byte[7:4]));
      p_other_none_r4: assert ((dec_op_byte == 8'h40 || dec_op_byte == 8'h50)
                               || (src_a == NONE && src_b == NONE && dst_load == NONE));
      p_none_zero_r5:  assert ((src_a != NONE || opnd_a == '0) && (src_b != NONE || opnd_b == '0));
      p_mem_wins_r6:   assert ((src_a == NONE || src_a != mem_dst || opnd_a == mem_load_val)
                               && (src_b == NONE || src_b != mem_dst || opnd_b == mem_load_val));
      p_wb_fwd_r7:     assert ((src_a == NONE || src_a == mem_dst || src_a != wb_dst || opnd_a == wb_val)
                               && (src_b == NONE || src_b == mem_dst || src_b != wb_dst || opnd_b == wb_val));
      p_rf_path_r8:    assert ((src_a == NONE || src_a == mem_dst || src_a == wb_dst || opnd_a == rf_rdata_a)
                               && (src_b == NONE || src_b == mem_dst || src_b == wb_dst || opnd_b == rf_rdata_b));
    end
  end
endmodule

bind dec_opnd_fwd dec_opnd_fwd_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dec_opnd_fwd.sv
module tb_dec_opnd_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 4;
  localparam int DW = 64;
  localparam logic [RW-1:0] NONE = 4'hF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]    op, rb_byte;
  logic [RW-1:0] mdst, wdst;
  logic [DW-1:0] mval, wval, rfa, rfb;
  logic [RW-1:0] sa, sb, dl;
  logic [DW-1:0] oa, ob;

  int checks = 0;
  int fails  = 0;
  bit done = 0;

  dec_opnd_fwd dut (
    .dec_op_byte(op), .dec_reg_byte(rb_byte),
    .mem_dst(mdst), .mem_load_val(mval),
    .wb_dst(wdst), .wb_val(wval),
    .rf_rdata_a(rfa), .rf_rdata_b(rfb),
    .src_a(sa), .src_b(sb), .dst_load(dl),
    .opnd_a(oa), .opnd_b(ob)
  );

  function automatic logic [RW-1:0] e_src_a(logic [7:0] o, logic [7:0] r);
    return (o == 8'h40) ? r[7:4] : NONE;
  endfunction
  function automatic logic [RW-1:0] e_src_b(logic [7:0] o, logic [7:0] r);
    return (o == 8'h40 || o == 8'h50) ? r[3:0] : NONE;
  endfunction
  function automatic logic [RW-1:0] e_dst(logic [7:0] o, logic [7:0] r);
    return (o == 8'h50) ? r[7:4] : NONE;
  endfunction
  function automatic logic [DW-1:0] e_opnd(logic [RW-1:0] s, logic [DW-1:0] rf);
    if (s == NONE) return '0;
    if (s == mdst) return mval;
    if (s == wdst) return wval;
    return rf;
  endfunction

  function automatic string opnd_req(logic [RW-1:0] s);
    if (s == NONE) return "R5";
    if (s == mdst) return "R6";
    if (s == wdst) return "R7";
    return "R8";
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] o, logic [7:0] r, logic [RW-1:0] md, logic [RW-1:0] wd);
    @(posedge clk);
    op = o; rb_byte = r; mdst = md; wdst = wd;
    mval = {$urandom, $urandom}; wval = {$urandom, $urandom};
    rfa  = {$urandom, $urandom}; rfb  = {$urandom, $urandom};
    @(negedge clk);
  endtask

  task automatic check_all();
    string rq;
    if (op == 8'h40 || op == 8'h50) rq = "R1"; else rq = "R4";
    chk(rq, DW'(sa), DW'(e_src_a(op, rb_byte)), "src_a");
    if (op == 8'h40 || op == 8'h50) rq = "R2"; else rq = "R4";
    chk(rq, DW'(sb), DW'(e_src_b(op, rb_byte)), "src_b");
    if (op == 8'h40 || op == 8'h50) rq = "R3"; else rq = "R4";
    chk(rq, DW'(dl), DW'(e_dst(op, rb_byte)), "dst_load");
    chk(opnd_req(e_src_a(op, rb_byte)), oa, e_opnd(e_src_a(op, rb_byte), rfa), "opnd_a");
    chk(opnd_req(e_src_b(op, rb_byte)), ob, e_opnd(e_src_b(op, rb_byte), rfb), "opnd_b");
  endtask

  initial begin
    int seed;
    logic [7:0] ops [4];
    seed = $urandom(32'h1D3C);
    ops[0] = 8'h50; ops[1] = 8'h40; ops[2] = 8'h00; ops[3] = 8'h00;
    op = 8'h00; rb_byte = 8'h00; mdst = NONE; wdst = NONE;
    mval = '0; wval = '0; rfa = '0; rfb = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Initial (halt, no stage destinations): everything none / zero (R4, R5)
    check_all();
    // Store r3 -> r5 base; no match: register file (R1, R2, R8)
    apply(8'h40, 8'h35, 4'h7, 4'h8); check_all();
    // Store, both stages match both sources: memory stage wins (R6)
    apply(8'h40, 8'h33, 4'h3, 4'h3); check_all();
    chk("R6", oa, mval, "opnd_a both-match");
    chk("R6", ob, mval, "opnd_b both-match");
    // Store, only writeback matches A, memory matches B (R6, R7)
    apply(8'h40, 8'h12, 4'h2, 4'h1); check_all();
    chk("R7", oa, wval, "opnd_a wb-only");
    // Load: source A none while both destinations are none code (R5, R3)
    apply(8'h50, 8'h9A, NONE, NONE); check_all();
    chk("R5", oa, '0, "opnd_a none vs none dst");
    chk("R3", DW'(dl), DW'(4'h9), "load dst");
    // Store with rA = none and matching none destinations (R5)
    apply(8'h40, 8'hF4, NONE, NONE); check_all();
    chk("R5", oa, '0, "store none src");
    // Halt and an unused byte (R4)
    apply(8'h00, 8'h12, 4'h1, 4'h2); check_all();
    chk("R4", ob, '0, "halt opnd_b");
    apply(8'h45, 8'h12, 4'h1, 4'h2); check_all();
    chk("R4", DW'(sa), DW'(NONE), "near-store byte");
    // Random mix with matches biased in
    for (int i = 0; i < 600; i++) begin
      logic [7:0] o, r;
      logic [RW-1:0] md, wd;
      o = ops[$urandom_range(0, 3)];
      if ($urandom_range(0, 7) == 0) o = 8'($urandom);
      r = 8'($urandom);
      md = RW'($urandom); wd = RW'($urandom);
      case ($urandom_range(0, 4))
        0: md = r[7:4];
        1: wd = r[3:0];
        2: begin md = r[3:0]; wd = r[3:0]; end
        3: begin md = r[7:4]; wd = r[7:4]; end
        default: ;
      endcase
      apply(o, r, md, wd);
      check_all();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule